// File: doc/BRIEF.md
# Command Ring Free-Space Watchdog

This block sits beside a circular command ring whose consumer advances a head pointer while a producer advances a tail pointer. On every clock it works out how many bytes the producer may still write without catching up with the consumer. A guard gap of 8 bytes is always held back, so the pointers can never meet from the producer side. It also reports when the ring holds nothing, which is when the two pointers are equal.

A producer that wants to write a burst strobes a request with its byte count. From the next clock the block polls: each clock compares the current free space with the latched count. As soon as the space is large enough it pulses a grant. The consumer may stall. A stall counter counts the polls in which the head pointer did not move. Any poll that sees the head at a new position sets that counter back to zero, so a slow but live consumer never trips it. When the counter reaches its limit with no grant, the block pulses a timeout instead.

Top module: `ring_space_watchdog`

## Requirements
- R1: `space_o` equals (head − tail − 8) modulo the ring size, computed from the head, tail and size present in the previous clock cycle (one register stage).
- R2: When head − (tail + 8) is negative the ring size is added, so `space_o` is always a multiple of 8 in the range 0 to size − 8.
- R3: Head and tail are used only after masking with size − 1 and clearing their three low bits; bits 2..0 and bits at or above log2(size) have no effect on any output.
- R4: A request is latched on the clock where `req_i` is high. On each later clock (a poll) the block compares the free space from the current inputs with the latched byte count. `grant_o` is high for the cycle after the first poll whose space is at least that count, and a count of 0 is granted on the first poll.
- R5: If STALL_LIMIT consecutive polls fail and see an unchanged head, `timeout_o` is high for the cycle after the last of them and the request ends. If both could happen on one poll, the grant wins.
- R6: A failing poll whose masked head differs from the head of the previous poll (or from the head seen at the request) sets the stall count back to zero, which delays the timeout.
- R7: `empty_o` is high, one cycle after the inputs, exactly when the masked head equals the masked tail. At that point `space_o` is size − 8.
- R8: A request while one is already pending replaces it. The byte count is re-latched, the stall count restarts, and neither pulse appears in the cycle after the request.
- R9: `grant_o` and `timeout_o` are never high together and never for two cycles in a row. With no request pending both stay low, and every output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_i | input | ADDR_W | Consumer byte pointer |
| tail_i | input | ADDR_W | Producer byte pointer |
| ring_size_i | input | ADDR_W+1 | Ring size in bytes, a power of two, at least 16 |
| req_i | input | 1 | Request strobe |
| req_bytes_i | input | ADDR_W+1 | Bytes wanted, latched with `req_i` |
| space_o | output | ADDR_W+1 | Free bytes, registered |
| grant_o | output | 1 | One-cycle pulse: request satisfied |
| timeout_o | output | 1 | One-cycle pulse: consumer stalled |
| empty_o | output | 1 | Ring empty, registered |

## Verification
The hardest case to reach from the ports is a timeout that a head movement in the middle of the window has pushed back. It needs a request that can never fit, a head held still for part of the window, then one step of the head that still leaves too little space, then a hold. The bench scripts this sequence and checks that the timeout arrives exactly STALL_LIMIT polls after the step. A separate case re-requests in the middle of a stall to show the window restarting. A behavioural model running on every clock covers random pointer traffic in which the head rarely moves.

// File: rtl/rfw_pkg.sv
package rfw_pkg;
  localparam int GUARD_BYTES = 8;
  localparam int ALIGN_BITS  = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rfw_state_e;
endpackage

// File: rtl/rfw_space_calc.sv
module rfw_space_calc
  import rfw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] head_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic [ADDR_W:0]   size_i,
  output logic [ADDR_W-1:0] head_m_o,
  output logic [ADDR_W:0]   space_now_o,
  output logic [ADDR_W:0]   space_q_o,
  output logic              empty_q_o
);
  localparam int SW = ADDR_W + 2;

  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] align_mask;
  logic [ADDR_W-1:0] tail_m;
  logic [SW-1:0]     diff;
  logic [SW-1:0]     wrapped;

  // size_i[ADDR_W-1:0]-1 is all ones when the ring spans the whole address space
  assign wrap_mask  = size_i[ADDR_W-1:0] - ADDR_W'(1);
  assign align_mask = {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  assign head_m_o   = head_i & wrap_mask & align_mask;
  assign tail_m     = tail_i & wrap_mask & align_mask;

  always_comb begin
    diff    = {2'b00, head_m_o} - {2'b00, tail_m} - SW'(GUARD_BYTES);
    wrapped = diff[SW-1] ? diff + {1'b0, size_i} : diff;
    space_now_o = wrapped[ADDR_W:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      space_q_o <= '0;
      empty_q_o <= 1'b0;
    end else begin
      space_q_o <= space_now_o;
      empty_q_o <= (head_m_o == tail_m);
    end
  end

  // R2: registered space stays aligned and below size minus guard
  a_r2_space_range : assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (space_q_o[2:0] == 3'b000) &&
                    (space_q_o <= $past(size_i) - (ADDR_W+1)'(GUARD_BYTES)));

  // R7: an empty ring shows the full usable space
  a_r7_empty_space : assert property (@(posedge clk) disable iff (rst)
    empty_q_o |-> (space_q_o == $past(size_i) - (ADDR_W+1)'(GUARD_BYTES)));
endmodule

// File: rtl/rfw_stall_timer.sv
module rfw_stall_timer #(
  parameter int ADDR_W      = 16,
  parameter int STALL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              poll_i,
  input  logic [ADDR_W-1:0] head_i,
  output logic              expired_o
);
  localparam int CW = $clog2(STALL_LIMIT + 1);

  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] last_head_q;
  logic              moved;

  assign moved     = (head_i != last_head_q);
  assign expired_o = poll_i && !moved && (cnt_q == CW'(STALL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      last_head_q <= '0;
    end else if (load_i) begin
      cnt_q       <= '0;
      last_head_q <= head_i;
    end else if (poll_i) begin
      last_head_q <= head_i;
      cnt_q       <= moved ? '0 : cnt_q + CW'(1);
    end
  end

  // R5: the count never runs past the limit
  a_r5_cnt_bound : assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(STALL_LIMIT));

  // R6: a poll that saw a new head leaves an empty window
  a_r6_move_restart : assert property (@(posedge clk) disable iff (rst)
    (poll_i && moved && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rfw_req_ctrl.sv
module rfw_req_ctrl
  import rfw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [ADDR_W:0] req_bytes_i,
  input  logic [ADDR_W:0] space_now_i,
  input  logic            expired_i,
  output logic            poll_o,
  output logic            grant_o,
  output logic            timeout_o
);
  rfw_state_e      state_q;
  logic [ADDR_W:0] need_q;
  logic            enough;

  assign enough = (space_now_i >= need_q);
  assign poll_o = (state_q == ST_WAIT) && !req_i && !enough;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      need_q    <= '0;
      grant_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      grant_o   <= 1'b0;
      timeout_o <= 1'b0;
      if (req_i) begin
        state_q <= ST_WAIT;
        need_q  <= req_bytes_i;
      end else if (state_q == ST_WAIT) begin
        if (enough) begin
          grant_o <= 1'b1;
          state_q <= ST_IDLE;
        end else if (expired_i) begin
          timeout_o <= 1'b1;
          state_q   <= ST_IDLE;
        end
      end
    end
  end

  // R9: outcomes are exclusive one-cycle pulses
  a_r9_exclusive : assert property (@(posedge clk) disable iff (rst)
    !(grant_o && timeout_o));
  a_r9_grant_pulse : assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o);
  a_r9_tmo_pulse : assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

  // R8: a request cycle yields no outcome on the next cycle
  a_r8_req_clears : assert property (@(posedge clk) disable iff (rst)
    req_i |=> !grant_o && !timeout_o);
endmodule

// File: rtl/ring_space_watchdog.sv
module ring_space_watchdog #(
  parameter int ADDR_W      = 16,
  parameter int STALL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] head_i,
  input  logic [ADDR_W-1:0] tail_i,
  input  logic [ADDR_W:0]   ring_size_i,
  input  logic              req_i,
  input  logic [ADDR_W:0]   req_bytes_i,
  output logic [ADDR_W:0]   space_o,
  output logic              grant_o,
  output logic              timeout_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] head_m;
  logic [ADDR_W:0]   space_now;
  logic              poll;
  logic              expired;

  rfw_space_calc #(.ADDR_W(ADDR_W)) u_space (
    .clk         (clk),
    .rst         (rst),
    .head_i      (head_i),
    .tail_i      (tail_i),
    .size_i      (ring_size_i),
    .head_m_o    (head_m),
    .space_now_o (space_now),
    .space_q_o   (space_o),
    .empty_q_o   (empty_o)
  );

  rfw_stall_timer #(.ADDR_W(ADDR_W), .STALL_LIMIT(STALL_LIMIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (req_i),
    .poll_i    (poll),
    .head_i    (head_m),
    .expired_o (expired)
  );

  rfw_req_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .req_bytes_i (req_bytes_i),
    .space_now_i (space_now),
    .expired_i   (expired),
    .poll_o      (poll),
    .grant_o     (grant_o),
    .timeout_o   (timeout_o)
  );

  // R5: a timeout follows a poll whose head matched the one before it
  a_r5_stable_head : assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> ($past(head_m, 1) == $past(head_m, 2)));
endmodule

// File: tb/tb_ring_space_watchdog.sv
module tb_ring_space_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int LIM = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] head, tail;
  logic [AW:0]   size;
  logic          req;
  logic [AW:0]   req_bytes;
  logic [AW:0]   space_o;
  logic          grant_o, timeout_o, empty_o;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  ring_space_watchdog #(.ADDR_W(AW), .STALL_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .head_i(head), .tail_i(tail), .ring_size_i(size),
    .req_i(req), .req_bytes_i(req_bytes), .space_o(space_o),
    .grant_o(grant_o), .timeout_o(timeout_o), .empty_o(empty_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int e_space = 0, e_grant = 0, e_tmo = 0, e_empty = 0;
  int m_wait = 0, m_need = 0, m_cnt = 0, m_last = 0;

  always @(posedge clk) begin
    int hm, tm, d;
    started = 1'b1;
    hm = int'(head) % int'(size); hm = hm - (hm % 8);
    tm = int'(tail) % int'(size); tm = tm - (tm % 8);
    d = hm - (tm + 8);
    if (d < 0) d = d + int'(size);
    if (rst) begin
      e_space = 0; e_grant = 0; e_tmo = 0; e_empty = 0;
      m_wait = 0; m_need = 0; m_cnt = 0; m_last = 0;
    end else begin
      e_space = d;
      e_empty = (hm == tm) ? 1 : 0;
      e_grant = 0;
      e_tmo = 0;
      if (req) begin
        m_wait = 1; m_need = int'(req_bytes); m_cnt = 0; m_last = hm;
      end else if (m_wait != 0) begin
        if (d >= m_need) begin
          e_grant = 1; m_wait = 0;
        end else begin
          if (hm != m_last) m_cnt = 0;
          else begin
            m_cnt++;
            if (m_cnt == LIM) begin e_tmo = 1; m_wait = 0; end
          end
          m_last = hm;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk("R1 model space", int'(space_o), e_space);
      chk("R7 model empty", int'(empty_o), e_empty);
      chk("R4 model grant", int'(grant_o), e_grant);
      chk("R5 model timeout", int'(timeout_o), e_tmo);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // issue a request, then poll until an outcome; returns poll index (0 if none)
  task automatic request_and_wait(input int bytes, input int move_at,
                                  input logic [AW-1:0] move_to,
                                  output int polls, output int got_grant);
    req = 1'b1; req_bytes = (AW+1)'(bytes);
    step();
    req = 1'b0;
    polls = 0; got_grant = 0;
    for (int k = 1; k <= 4*LIM; k++) begin
      if (k == move_at) head = move_to;
      step();
      if (grant_o) begin polls = k; got_grant = 1; break; end
      if (timeout_o) begin polls = k; break; end
    end
  endtask

  initial begin
    int n, g;
    rst = 1'b1; head = '0; tail = '0; size = (AW+1)'(64);
    req = 1'b0; req_bytes = '0;
    step(); step();
    chk("R9 reset space", int'(space_o), 0);
    chk("R9 reset grant", int'(grant_o), 0);
    chk("R9 reset timeout", int'(timeout_o), 0);
    chk("R9 reset empty", int'(empty_o), 0);
    rst = 1'b0;

    head = 8'd0; tail = 8'd0; step();
    chk("R7 empty flag", int'(empty_o), 1);
    chk("R7 empty space", int'(space_o), 56);

    head = 8'd40; tail = 8'd8; step();
    chk("R1 plain space", int'(space_o), 24);
    chk("R7 not empty", int'(empty_o), 0);

    head = 8'd8; tail = 8'd48; step();
    chk("R2 wrapped space", int'(space_o), 16);

    head = 8'd72 | 8'd5; tail = 8'd48 | 8'd3; step();
    chk("R3 masked bits", int'(space_o), 16);

    head = 8'd40; tail = 8'd8; step();
    request_and_wait(24, 0, '0, n, g);
    chk("R4 grant exact fit", g, 1);
    chk("R4 grant first poll", n, 1);
    step();
    chk("R9 grant single cycle", int'(grant_o), 0);

    request_and_wait(32, 0, '0, n, g);
    chk("R5 timeout no grant", g, 0);
    chk("R5 timeout poll", n, LIM);
    step();
    chk("R9 timeout single cycle", int'(timeout_o), 0);

    request_and_wait(32, 6, 8'd32, n, g);
    chk("R6 restart no grant", g, 0);
    chk("R6 delayed timeout", n, 6 + LIM);

    head = 8'd40; step();
    req = 1'b1; req_bytes = (AW+1)'(32); step(); req = 1'b0;
    for (int k = 0; k < 8; k++) step();
    request_and_wait(32, 0, '0, n, g);
    chk("R8 rerequest restarts window", n, LIM);

    head = 8'd16; tail = 8'd8; step();
    request_and_wait(0, 0, '0, n, g);
    chk("R4 zero bytes granted", g, 1);
    chk("R4 zero bytes poll", n, 1);

    for (int c = 0; c < 600; c++) begin
      if ($urandom_range(0, 7) == 0) head = AW'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) tail = AW'($urandom_range(0, 255));
      req = ($urandom_range(0, 9) == 0);
      req_bytes = (AW+1)'($urandom_range(0, 64));
      step();
    end
    req = 1'b0;
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired R4 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule